// File: doc/BRIEF.md
# Virtualized Timestamp Read Unit

This block computes the 64-bit value a guest receives when it reads one of two model-specific registers: the timestamp counter and the timer deadline. For the counter, a pair of controls chooses the value. If offsetting is off, the raw count comes back unchanged. If offsetting is on and scaling is off, a signed 64-bit offset is added to the count. If both are on, the count is multiplied by a 16.48 fixed-point multiplier, the product is shifted down by 48 bits and the offset is then added. A deadline read always returns the raw deadline value and never applies the offset.

A request is taken on any clock edge where `reqValid` is high and `busy` is low. Unscaled reads finish in one cycle. A scaled read goes through an iterative multiplier that consumes 16 multiplier bits per cycle. It holds `busy` high while it runs, and the unit takes no new request during that time. Each completion raises `resultValid` for a single cycle. The result is presented as two 32-bit halves, and it holds until the next completion.

Top module: `tstamp_read_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `busy` and `resultValid` are low and both result halves are zero.
- R2: Index 0x010 with offsetting disabled returns `rawCount` unchanged, whatever the scaling control says. `resultValid` is high one cycle after the accepting edge, and `busy` stays low.
- R3: Index 0x010 with offsetting enabled and scaling disabled returns `rawCount + offsetVal` modulo 2^64, one cycle after acceptance.
- R4: Index 0x010 with both controls enabled returns bits [111:48] of the full 128-bit product `rawCount * multVal`, plus `offsetVal`, modulo 2^64.
- R5: A scaled read raises `busy` on the edge that accepts it. `busy` stays high for exactly five cycles. `resultValid` rises on the edge where `busy` falls, which is five edges after acceptance.
- R6: A request presented while `busy` is high is ignored: it produces no completion of its own and does not alter the result in progress.
- R7: Index 0x6E0 returns `deadlineVal` unchanged, even when offsetting and scaling are enabled, one cycle after acceptance.
- R8: Any other index returns zero one cycle after acceptance.
- R9: `resultLo` carries result bits [31:0] and `resultHi` carries bits [63:32].
- R10: Every accepted request yields exactly one single-cycle `resultValid` pulse. Unscaled requests can be accepted on consecutive cycles.
- R11: The result halves change only on a cycle where `resultValid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Read request; taken when `busy` is low |
| regIndex | input | 12 | Register index of the read |
| rawCount | input | 64 | Raw timestamp count |
| offsetVal | input | 64 | Two's-complement offset |
| multVal | input | 64 | Multiplier, 16 integer and 48 fraction bits |
| offsetEn | input | 1 | Offsetting enable |
| scaleEn | input | 1 | Scaling enable, used only when offsetting is enabled |
| deadlineVal | input | 64 | Raw timer deadline value |
| busy | output | 1 | Scaled read in progress |
| resultValid | output | 1 | One-cycle completion pulse |
| resultLo | output | 32 | Result bits [31:0] |
| resultHi | output | 32 | Result bits [63:32] |

## Verification
The path assertions compare the output with the request's operands as they stood on the accepting edge, using `$past` of the inputs. They therefore assume that index, controls and operands are free of X whenever `reqValid` is high. The bench meets this by driving every input to a known value on each request and by keeping `reqValid` low except during a deliberate request. The hold check assumes that reset starts with known zeros in the result. The bench therefore holds reset for several edges before its first request.

// File: rtl/tstamp_read_pkg.sv
package tstamp_read_pkg;

  // Which value the one-cycle path loads into the result register
  typedef enum logic [1:0] {
    SRC_ZERO     = 2'd0,
    SRC_RAW      = 2'd1,
    SRC_SUM      = 2'd2,
    SRC_DEADLINE = 2'd3
  } srcSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    loadDirect;
    srcSel_e src;
    logic    loadMul;
    logic    stepMul;
    logic    finishMul;
  } dpCtl_t;

endpackage

// File: rtl/tstamp_read_ctrl.sv
module tstamp_read_ctrl
  import tstamp_read_pkg::*;
#(
  parameter int IDX_W = 12,
  parameter logic [IDX_W-1:0] COUNT_IDX = 12'h010,
  parameter logic [IDX_W-1:0] DEADLINE_IDX = 12'h6E0,
  parameter int NUM_STEPS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [IDX_W-1:0] regIndex,
  input  logic             offsetEn,
  input  logic             scaleEn,
  output dpCtl_t           ctl,
  output logic             busy,
  output logic             resultValid
);

  localparam int STEP_W = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_FIN  = 2'd2
  } state_e;

  state_e            state;
  logic [STEP_W-1:0] stepCnt;
  logic              validR;
  logic              accept;
  logic              isCount;
  logic              isDeadline;
  logic              wantScale;

  assign accept     = reqValid && (state == ST_IDLE);
  assign isCount    = (regIndex == COUNT_IDX);
  assign isDeadline = (regIndex == DEADLINE_IDX);
  assign wantScale  = isCount && offsetEn && scaleEn;

  always_comb begin
    ctl = '0;
    if (isCount) ctl.src = offsetEn ? SRC_SUM : SRC_RAW;
    else if (isDeadline) ctl.src = SRC_DEADLINE;
    else ctl.src = SRC_ZERO;
    ctl.loadDirect = accept && !wantScale;
    ctl.loadMul    = accept && wantScale;
    ctl.stepMul    = (state == ST_MUL);
    ctl.finishMul  = (state == ST_FIN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      validR  <= 1'b0;
    end else begin
      validR <= ctl.loadDirect || ctl.finishMul;
      unique case (state)
        ST_IDLE: begin
          if (ctl.loadMul) begin
            state   <= ST_MUL;
            stepCnt <= '0;
          end
        end
        ST_MUL: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LAST_STEP) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state != ST_IDLE);
  assign resultValid = validR;

endmodule

// File: rtl/tstamp_read_dp.sv
module tstamp_read_dp
  import tstamp_read_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int SLICE_W = 16,
  parameter int FRAC_W  = 48
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic [CNT_W-1:0]   rawCount,
  input  logic [CNT_W-1:0]   offsetVal,
  input  logic [CNT_W-1:0]   multVal,
  input  logic [CNT_W-1:0]   deadlineVal,
  output logic [CNT_W/2-1:0] resultLo,
  output logic [CNT_W/2-1:0] resultHi
);

  // Product bits above ACC_W never reach the result, so the accumulator stops there
  localparam int ACC_W  = FRAC_W + CNT_W;
  localparam int HALF_W = CNT_W / 2;

  logic [ACC_W-1:0] cntShR;
  logic [CNT_W-1:0] mulR;
  logic [CNT_W-1:0] offR;
  logic [ACC_W-1:0] accR;
  logic [CNT_W-1:0] resultR;
  logic [CNT_W-1:0] directVal;
  logic [ACC_W-1:0] partial;

  always_comb begin
    unique case (ctl.src)
      SRC_RAW:      directVal = rawCount;
      SRC_SUM:      directVal = rawCount + offsetVal;
      SRC_DEADLINE: directVal = deadlineVal;
      default:      directVal = '0;
    endcase
  end

  // One partial product per step: shifted count times the current multiplier slice
  assign partial = cntShR * ACC_W'(mulR[SLICE_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntShR  <= '0;
      mulR    <= '0;
      offR    <= '0;
      accR    <= '0;
      resultR <= '0;
    end else begin
      if (ctl.loadDirect) resultR <= directVal;
      if (ctl.loadMul) begin
        cntShR <= ACC_W'(rawCount);
        mulR   <= multVal;
        offR   <= offsetVal;
        accR   <= '0;
      end
      if (ctl.stepMul) begin
        accR   <= accR + partial;
        cntShR <= cntShR << SLICE_W;
        mulR   <= mulR >> SLICE_W;
      end
      if (ctl.finishMul) resultR <= accR[ACC_W-1:FRAC_W] + offR;
    end
  end

  logic [HALF_W-1:0] halves [2];
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign halves[h] = resultR[h*HALF_W +: HALF_W];
  end
  assign resultLo = halves[0];
  assign resultHi = halves[1];

endmodule

// File: rtl/tstamp_read_unit.sv
module tstamp_read_unit
  import tstamp_read_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int SLICE_W = 16,
  parameter int FRAC_W  = 48,
  parameter int IDX_W   = 12,
  parameter logic [IDX_W-1:0] COUNT_IDX = 12'h010,
  parameter logic [IDX_W-1:0] DEADLINE_IDX = 12'h6E0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [IDX_W-1:0]   regIndex,
  input  logic [CNT_W-1:0]   rawCount,
  input  logic [CNT_W-1:0]   offsetVal,
  input  logic [CNT_W-1:0]   multVal,
  input  logic               offsetEn,
  input  logic               scaleEn,
  input  logic [CNT_W-1:0]   deadlineVal,
  output logic               busy,
  output logic               resultValid,
  output logic [CNT_W/2-1:0] resultLo,
  output logic [CNT_W/2-1:0] resultHi
);

  localparam int NUM_STEPS = CNT_W / SLICE_W;

  dpCtl_t ctl;

  tstamp_read_ctrl #(
    .IDX_W(IDX_W), .COUNT_IDX(COUNT_IDX), .DEADLINE_IDX(DEADLINE_IDX), .NUM_STEPS(NUM_STEPS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .regIndex(regIndex),
    .offsetEn(offsetEn), .scaleEn(scaleEn), .ctl(ctl), .busy(busy),
    .resultValid(resultValid)
  );

  tstamp_read_dp #(
    .CNT_W(CNT_W), .SLICE_W(SLICE_W), .FRAC_W(FRAC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rawCount(rawCount), .offsetVal(offsetVal),
    .multVal(multVal), .deadlineVal(deadlineVal), .resultLo(resultLo), .resultHi(resultHi)
  );

endmodule

// File: rtl/tstamp_read_chk.sv
module tstamp_read_chk #(
  parameter int CNT_W   = 64,
  parameter int SLICE_W = 16,
  parameter int IDX_W   = 12,
  parameter logic [IDX_W-1:0] COUNT_IDX = 12'h010,
  parameter logic [IDX_W-1:0] DEADLINE_IDX = 12'h6E0
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic [IDX_W-1:0]   regIndex,
  input logic [CNT_W-1:0]   rawCount,
  input logic [CNT_W-1:0]   offsetVal,
  input logic               offsetEn,
  input logic               scaleEn,
  input logic [CNT_W-1:0]   deadlineVal,
  input logic               busy,
  input logic               resultValid,
  input logic [CNT_W/2-1:0] resultLo,
  input logic [CNT_W/2-1:0] resultHi
);

  localparam int NUM_STEPS = CNT_W / SLICE_W;

  logic             taken;
  logic             scaledReq;
  logic [CNT_W-1:0] res;
  logic [7:0]       busyRun;

  assign taken     = reqValid && !busy;
  assign scaledReq = (regIndex == COUNT_IDX) && offsetEn && scaleEn;
  assign res       = {resultHi, resultLo};

  always_ff @(posedge clk) begin
    if (!rstN || !busy) busyRun <= '0;
    else busyRun <= busyRun + 8'd1;
  end

  // R2
  raw_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    (taken && regIndex == COUNT_IDX && !offsetEn) |=> (resultValid && !busy && res == $past(rawCount)));

  // R3
  sum_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    (taken && regIndex == COUNT_IDX && offsetEn && !scaleEn) |=>
      (resultValid && res == $past(rawCount + offsetVal)));

  // R7
  deadline_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    (taken && regIndex == DEADLINE_IDX) |=> (resultValid && res == $past(deadlineVal)));

  // R8
  other_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (taken && regIndex != COUNT_IDX && regIndex != DEADLINE_IDX) |=> (resultValid && res == '0));

  // R5
  scaled_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (taken && scaledReq) |=> (busy && !resultValid));

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyRun <= 8'(NUM_STEPS)));

  // R5
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> resultValid);

  // R10
  valid_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> ($past(taken) || $past(busy)));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> $stable(res));

endmodule

bind tstamp_read_unit tstamp_read_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .regIndex(regIndex),
  .rawCount(rawCount), .offsetVal(offsetVal), .offsetEn(offsetEn), .scaleEn(scaleEn),
  .deadlineVal(deadlineVal), .busy(busy), .resultValid(resultValid),
  .resultLo(resultLo), .resultHi(resultHi)
);

// File: tb/test_tstamp_read_unit.sv
`timescale 1ns/1ps
module test_tstamp_read_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [11:0] regIndex = '0;
  logic [63:0] rawCount = '0;
  logic [63:0] offsetVal = '0;
  logic [63:0] multVal = '0;
  logic        offsetEn = 1'b0;
  logic        scaleEn = 1'b0;
  logic [63:0] deadlineVal = '0;
  logic        busy;
  logic        resultValid;
  logic [31:0] resultLo;
  logic [31:0] resultHi;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  tstamp_read_unit i_tstamp_read_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .regIndex(regIndex),
    .rawCount(rawCount), .offsetVal(offsetVal), .multVal(multVal),
    .offsetEn(offsetEn), .scaleEn(scaleEn), .deadlineVal(deadlineVal),
    .busy(busy), .resultValid(resultValid), .resultLo(resultLo), .resultHi(resultHi)
  );

  function automatic logic [63:0] refScaled(logic [63:0] c, logic [63:0] m, logic [63:0] o);
    logic [127:0] p;
    p = {64'd0, c} * {64'd0, m};
    return p[111:48] + o;
  endfunction

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check1(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Drive one request on a falling edge; returns on the falling edge after acceptance
  task automatic issue(logic [11:0] idx, logic [63:0] c, logic [63:0] o, logic [63:0] m,
                       logic oe, logic se, logic [63:0] dl);
    @(negedge clk);
    regIndex = idx; rawCount = c; offsetVal = o; multVal = m;
    offsetEn = oe; scaleEn = se; deadlineVal = dl; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic directRead(string tag, logic [11:0] idx, logic [63:0] c, logic [63:0] o,
                            logic oe, logic se, logic [63:0] dl, logic [63:0] exp);
    issue(idx, c, o, 64'h0001_0000_0000_0000, oe, se, dl);
    check1({tag, " valid"}, resultValid, 1'b1);
    check1({tag, " busy"}, busy, 1'b0);
    check64(tag, {resultHi, resultLo}, exp);
    @(negedge clk);
    check1({tag, " R10 single pulse"}, resultValid, 1'b0);
  endtask

  task automatic scaledRead(string tag, logic [63:0] c, logic [63:0] m, logic [63:0] o);
    issue(12'h010, c, o, m, 1'b1, 1'b1, 64'h0);
    check1({tag, " R5 busy raised"}, busy, 1'b1);
    check1({tag, " R5 no early valid"}, resultValid, 1'b0);
    repeat (4) @(negedge clk);
    check1({tag, " R5 busy in last step"}, busy, 1'b1);
    check1({tag, " R5 valid not yet"}, resultValid, 1'b0);
    @(negedge clk);
    check1({tag, " R5 valid"}, resultValid, 1'b1);
    check1({tag, " R5 busy cleared"}, busy, 1'b0);
    check64({tag, " R4"}, {resultHi, resultLo}, refScaled(c, m, o));
    @(negedge clk);
    check1({tag, " R10 single pulse"}, resultValid, 1'b0);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    check1("R1 busy in reset", busy, 1'b0);
    check1("R1 valid in reset", resultValid, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check1("R1 busy after reset", busy, 1'b0);
    check1("R1 valid after reset", resultValid, 1'b0);
    check64("R1 result after reset", {resultHi, resultLo}, 64'h0);
  endtask

  task automatic t_raw();
    directRead("R2 raw", 12'h010, 64'h0123_4567_89AB_CDEF, 64'h55, 1'b0, 1'b0, 64'h0, 64'h0123_4567_89AB_CDEF);
    directRead("R2 raw scale ignored", 12'h010, 64'hFEDC_BA98_7654_3210, 64'h99, 1'b0, 1'b1, 64'h0,
               64'hFEDC_BA98_7654_3210);
  endtask

  task automatic t_offset();
    directRead("R3 sum", 12'h010, 64'h1000, 64'h234, 1'b1, 1'b0, 64'h0, 64'h1234);
    directRead("R3 wrap", 12'h010, 64'hFFFF_FFFF_FFFF_FFF0, 64'h20, 1'b1, 1'b0, 64'h0, 64'h10);
    directRead("R3 negative", 12'h010, 64'h1000, 64'hFFFF_FFFF_FFFF_FF00, 1'b1, 1'b0, 64'h0, 64'hF00);
  endtask

  task automatic t_scaled();
    scaledRead("unity", 64'h1234_5678_9ABC_DEF0, 64'h0001_0000_0000_0000, 64'h0);
    scaledRead("double", 64'h9000_0000_0000_0001, 64'h0002_0000_0000_0000, 64'h3);
    scaledRead("half", 64'h0000_0000_0000_0101, 64'h0000_8000_0000_0000, 64'h10);
    scaledRead("max", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h5);
    scaledRead("mixed", 64'h0BAD_F00D_1357_2468, 64'h0001_2345_6789_ABCD, 64'hFFFF_FFFF_0000_0000);
  endtask

  task automatic t_deadline();
    directRead("R7 deadline offset on", 12'h6E0, 64'h5, 64'h1111, 1'b1, 1'b0, 64'hCAFE_0000_BEEF_0001,
               64'hCAFE_0000_BEEF_0001);
    directRead("R7 deadline scale on", 12'h6E0, 64'h5, 64'h1111, 1'b1, 1'b1, 64'h0000_0000_0000_0777,
               64'h777);
  endtask

  task automatic t_other();
    directRead("R8 other index", 12'h011, 64'hAAAA, 64'h1, 1'b1, 1'b0, 64'hBBBB, 64'h0);
  endtask

  task automatic t_halves();
    directRead("R9 halves", 12'h010, 64'hDEAD_BEEF_0BAD_CAFE, 64'h0, 1'b0, 1'b0, 64'h0,
               64'hDEAD_BEEF_0BAD_CAFE);
    check64("R9 low half", {32'h0, resultLo}, 64'h0BAD_CAFE);
    check64("R9 high half", {32'h0, resultHi}, 64'hDEAD_BEEF);
  endtask

  task automatic t_busyIgnore();
    logic [63:0] exp;
    exp = refScaled(64'h0000_1234_0000_5678, 64'h0003_0000_0000_0000, 64'h7);
    issue(12'h010, 64'h0000_1234_0000_5678, 64'h7, 64'h0003_0000_0000_0000, 1'b1, 1'b1, 64'h0);
    regIndex = 12'h6E0; deadlineVal = 64'h9999; offsetEn = 1'b0; scaleEn = 1'b0;
    rawCount = 64'h1; offsetVal = 64'h1; multVal = 64'h1; reqValid = 1'b1;
    repeat (4) @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    check1("R6 valid for first only", resultValid, 1'b1);
    check64("R6 result unaffected", {resultHi, resultLo}, exp);
    @(negedge clk);
    check1("R6 no extra completion", resultValid, 1'b0);
    check64("R11 result held", {resultHi, resultLo}, exp);
    repeat (3) @(negedge clk);
    check1("R6 still idle", resultValid, 1'b0);
    check1("R6 not busy", busy, 1'b0);
  endtask

  task automatic t_backToBack();
    @(negedge clk);
    regIndex = 12'h010; rawCount = 64'hA1; offsetEn = 1'b0; scaleEn = 1'b0; reqValid = 1'b1;
    @(negedge clk);
    check1("R10 b2b valid 1", resultValid, 1'b1);
    check64("R10 b2b result 1", {resultHi, resultLo}, 64'hA1);
    rawCount = 64'hB2; offsetEn = 1'b1; offsetVal = 64'h10;
    @(negedge clk);
    check1("R10 b2b valid 2", resultValid, 1'b1);
    check64("R10 b2b result 2", {resultHi, resultLo}, 64'hC2);
    regIndex = 12'h6E0; deadlineVal = 64'hD3;
    @(negedge clk);
    check1("R10 b2b valid 3", resultValid, 1'b1);
    check64("R10 b2b result 3", {resultHi, resultLo}, 64'hD3);
    reqValid = 1'b0;
    @(negedge clk);
    check1("R10 b2b ends", resultValid, 1'b0);
    check64("R11 b2b held", {resultHi, resultLo}, 64'hD3);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        bad++;
        total++;
        $display("FAIL R5 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_raw();
    t_offset();
    t_scaled();
    t_deadline();
    t_other();
    t_halves();
    t_busyIgnore();
    t_backToBack();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule